// File: doc/BRIEF.md
# Test Traffic Sender

This block is the transmit half of a traffic-generating test node in an on-chip network. It issues packets on an elastic output channel: the block drives a valid flag and a 9-bit word, and the downstream side returns a stall flag. Each word carries a 3-bit destination and a 6-bit send time. The send time comes from a free-running counter. It is captured when the packet is formed, so any cycles the packet then waits behind a stall count toward the latency that the receiver measures.

The destination comes from one of three sources. The first is a 3-bit pseudo-random LFSR. The second is an eight-entry rotating sequence loaded by software. The third is an echo mode, in which every packet received from the network is answered with a reply to its sender. Echo requests wait in a small queue, and the queue stalls the receive side when it fills. A gap setting limits how often packets are formed. Configuration goes through a plain write port.

Top module: `traffic_sender`

## Requirements
- R1: After reset `txValid` and `rxStall` are 0. The output word is `txData[8:6]` = destination and `txData[5:0]` = send time.
- R2: While `txValid` and `txStall` are both 1, the next cycle still has `txValid` = 1 and an unchanged `txData`.
- R3: A packet transfers on a clock edge where `txValid` = 1 and `txStall` = 0. A new packet may load into the output register on that same edge, so with gap 0 one packet leaves every cycle.
- R4: A 6-bit time counter resets to 0 and adds 1 every cycle, wrapping modulo 64. A generated packet carries the counter value from the cycle in which it was formed, which is the cycle before it first shows on `txValid`.
- R5: Mode 0 (random) takes the destination from a 3-bit LFSR that resets to 1 and steps as next = {s[1:0], s[2]^s[1]} on each packet formed. A write to address 2 loads `cfgData[2:0]` as the new state; a write of 0 leaves the state unchanged.
- R6: Mode 1 (pattern) sends the head of an eight-entry sequence and rotates the head to the tail on each packet formed. A write to address 3 shifts `cfgData[2:0]` in at the tail and drops the head, so after eight writes the entries go out in the order written and repeat every eight packets.
- R7: In mode 2 (echo) a receive word is taken on an edge with `rxValid` = 1 and `rxStall` = 0. It queues a reply whose destination is `rxSrc` and whose send time is the counter value at that edge. Replies leave in arrival order, and no generated traffic is sent in this mode.
- R8: The echo queue holds ECHO_DEPTH entries. `rxStall` = 1 exactly when the mode is echo and the queue is full. In the other modes `rxStall` stays 0 and receive words are dropped.
- R9: Address 1 sets a gap g (`cfgData[5:0]`). After a packet is formed, the next one is formed no earlier than g+1 cycles later.
- R10: No packet is formed while the run bit is 0, while the mode is 3, or in a cycle with `cfgWrEn` = 1. Address 0 writes run = `cfgData[0]` and mode = `cfgData[2:1]`. A packet already in the output register still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | 6 | Configuration write value |
| rxValid | input | 1 | Received packet present (echo trigger) |
| rxSrc | input | 3 | Sender address of the received packet |
| rxStall | output | 1 | Echo queue full, hold receive traffic |
| txValid | output | 1 | Output word valid |
| txData | output | 9 | Output word: destination and send time |
| txStall | input | 1 | Downstream stall |

## Verification
The bench aims at the edge where one packet leaves and the next loads under a stall that toggles cycle by cycle. A design that got this wrong would drop a word, repeat it, or open a bubble. Send times are compared exactly, so a stamp taken at transfer time instead of formation time shows up as soon as a stall is seen. The echo queue is driven to full while the output is stalled, and receive words are offered in the other modes; an overflowing or leaky queue would change the reply order or send extra replies. A zero seed write, writes landing in the middle of a stream, and gap values greater than 0 check that the LFSR never locks up and that the pacing counter neither skips nor stretches a slot.

// File: rtl/tg_pkg.sv
package tg_pkg;
  parameter int ADDR_W  = 3;
  parameter int STAMP_W = 6;
  parameter int WORD_W  = ADDR_W + STAMP_W;

  typedef enum logic [1:0] {
    MODE_RAND = 2'd0,
    MODE_PAT  = 2'd1,
    MODE_ECHO = 2'd2,
    MODE_OFF  = 2'd3
  } tg_mode_e;

  typedef struct packed {
    logic loadRand;
    logic loadPat;
    logic loadEcho;
    logic send;
    logic push;
    logic seedWr;
    logic patWr;
  } tg_strobe_t;

  function automatic logic [ADDR_W-1:0] lfsrNext(input logic [ADDR_W-1:0] s);
    return {s[1:0], s[2] ^ s[1]};
  endfunction
endpackage

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
#(
  parameter int GAP_W = STAMP_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [GAP_W-1:0] cfgData,
  input  logic             rxValid,
  input  logic             txStall,
  input  logic             pendValid,
  input  logic             qEmpty,
  input  logic             qFull,
  output logic             rxStall,
  output tg_strobe_t       strobe
);
  logic             runReg;
  tg_mode_e         modeReg;
  logic [GAP_W-1:0] gapReg;
  logic [GAP_W-1:0] paceCnt;
  logic             fire, slotFree, canGo, anyLoad;

  always_comb begin
    fire     = pendValid && !txStall;
    slotFree = !pendValid || fire;
    canGo    = runReg && (paceCnt == '0) && slotFree && !cfgWrEn;
    strobe.send     = fire;
    strobe.loadRand = canGo && (modeReg == MODE_RAND);
    strobe.loadPat  = canGo && (modeReg == MODE_PAT);
    strobe.loadEcho = canGo && (modeReg == MODE_ECHO) && !qEmpty;
    strobe.push     = (modeReg == MODE_ECHO) && rxValid && !qFull;
    strobe.seedWr   = cfgWrEn && (cfgAddr == 2'd2);
    strobe.patWr    = cfgWrEn && (cfgAddr == 2'd3);
    anyLoad  = strobe.loadRand || strobe.loadPat || strobe.loadEcho;
    rxStall  = (modeReg == MODE_ECHO) && qFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg  <= 1'b0;
      modeReg <= MODE_RAND;
      gapReg  <= '0;
      paceCnt <= '0;
    end else begin
      if (cfgWrEn && cfgAddr == 2'd0) begin
        runReg  <= cfgData[0];
        modeReg <= tg_mode_e'(cfgData[2:1]);
      end
      if (cfgWrEn && cfgAddr == 2'd1) gapReg <= cfgData;
      if (anyLoad)                paceCnt <= gapReg;
      else if (paceCnt != '0)     paceCnt <= paceCnt - 1'b1;
    end
  end

  // R9: a nonzero gap forbids back-to-back packet formation
  assert_pace_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (anyLoad && gapReg != '0) |=> !(strobe.loadRand || strobe.loadPat || strobe.loadEcho));

  // R8: receive stall only ever raised in echo mode
  assert_rxstall_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxStall |-> (modeReg == MODE_ECHO && !strobe.push));
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
#(
  parameter int PAT_DEPTH  = 8,
  parameter int ECHO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tg_strobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgVal,
  input  logic [ADDR_W-1:0] rxSrc,
  output logic              pendValid,
  output logic [WORD_W-1:0] pendWord,
  output logic              qEmpty,
  output logic              qFull
);
  localparam int PTR_W = (ECHO_DEPTH > 1) ? $clog2(ECHO_DEPTH) : 1;
  localparam int CNT_W = $clog2(ECHO_DEPTH + 1);

  logic [STAMP_W-1:0] tsCnt;
  logic [ADDR_W-1:0]  lfsrQ;
  logic [ADDR_W-1:0]  patQ [PAT_DEPTH];
  logic [WORD_W-1:0]  echoMem [ECHO_DEPTH];
  logic [PTR_W-1:0]   rdPtr, wrPtr;
  logic [CNT_W-1:0]   qCount;

  assign qEmpty = (qCount == '0);
  assign qFull  = (qCount == CNT_W'(ECHO_DEPTH));

  // time base
  always_ff @(posedge clk) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  // random destination source
  always_ff @(posedge clk) begin
    if (!rstN)                              lfsrQ <= ADDR_W'(1);
    else if (strobe.seedWr && cfgVal != '0) lfsrQ <= cfgVal;
    else if (strobe.loadRand)               lfsrQ <= lfsrNext(lfsrQ);
  end

  // programmed destination sequence: rotate on use, shift in on write
  generate
    for (genvar i = 0; i < PAT_DEPTH; i++) begin : g_pat
      always_ff @(posedge clk) begin
        if (!rstN) patQ[i] <= '0;
        else if (strobe.loadPat || strobe.patWr) begin
          if (i == PAT_DEPTH - 1) patQ[i] <= strobe.patWr ? cfgVal : patQ[0];
          else                    patQ[i] <= patQ[(i + 1) % PAT_DEPTH];
        end
      end
    end
  endgenerate

  // echo request queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strobe.push) begin
        echoMem[wrPtr] <= {rxSrc, tsCnt};
        wrPtr <= (wrPtr == PTR_W'(ECHO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.loadEcho)
        rdPtr <= (rdPtr == PTR_W'(ECHO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.loadEcho})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWord  <= '0;
    end else begin
      if (strobe.send) pendValid <= 1'b0;
      if (strobe.loadRand) begin
        pendValid <= 1'b1;
        pendWord  <= {lfsrQ, tsCnt};
      end else if (strobe.loadPat) begin
        pendValid <= 1'b1;
        pendWord  <= {patQ[0], tsCnt};
      end else if (strobe.loadEcho) begin
        pendValid <= 1'b1;
        pendWord  <= echoMem[rdPtr];
      end
    end
  end

  // R2: a stalled word is held unchanged
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !strobe.send) |=> (pendValid && $stable(pendWord)));

  // R8: queue never written beyond capacity
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (qCount < CNT_W'(ECHO_DEPTH)));

  // R5: LFSR never reaches the all-zero lock state
  assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  // R4: time base advances by one each cycle
  assert_ts_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (tsCnt == $past(tsCnt) + 1'b1));
endmodule

// File: rtl/traffic_sender.sv
module traffic_sender
  import tg_pkg::*;
#(
  parameter int PAT_DEPTH  = 8,
  parameter int ECHO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [STAMP_W-1:0] cfgData,
  input  logic              rxValid,
  input  logic [ADDR_W-1:0] rxSrc,
  output logic              rxStall,
  output logic              txValid,
  output logic [WORD_W-1:0] txData,
  input  logic              txStall
);
  tg_strobe_t strobe;
  logic       qEmpty, qFull;

  tg_ctrl #(.GAP_W(STAMP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .rxValid(rxValid), .txStall(txStall),
    .pendValid(txValid), .qEmpty(qEmpty), .qFull(qFull),
    .rxStall(rxStall), .strobe(strobe)
  );

  tg_datapath #(.PAT_DEPTH(PAT_DEPTH), .ECHO_DEPTH(ECHO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgVal(cfgData[ADDR_W-1:0]),
    .rxSrc(rxSrc), .pendValid(txValid), .pendWord(txData),
    .qEmpty(qEmpty), .qFull(qFull)
  );
endmodule

// File: tb/sim_traffic_sender.sv
module sim_traffic_sender;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [5:0] cfgData = '0;
  logic       rxValid = 1'b0;
  logic [2:0] rxSrc = '0;
  logic       rxStall, txValid, txStall = 1'b0;
  logic [8:0] txData;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  traffic_sender u0 (.clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .rxValid(rxValid), .rxSrc(rxSrc), .rxStall(rxStall),
    .txValid(txValid), .txData(txData), .txStall(txStall));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int mTs, mLfsr, mRun, mMode, mGap, mPace, mValid, mWord;
  int mPat[8];
  int mQ[$];

  function automatic int expRxStall();
    return (mMode == 2 && mQ.size() == DEPTH) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTs = 0; mLfsr = 1; mRun = 0; mMode = 0; mGap = 0; mPace = 0;
      mValid = 0; mWord = 0; mQ.delete();
      foreach (mPat[i]) mPat[i] = 0;
    end else begin
      bit fire, load, push;
      int h;
      fire = mValid && !txStall;
      load = (!mValid || fire) && mRun && mPace == 0 && !cfgWrEn && mMode != 3
             && (mMode != 2 || mQ.size() > 0);
      push = mMode == 2 && rxValid && mQ.size() < DEPTH;
      if (fire) mValid = 0;
      if (load) begin
        mValid = 1;
        if (mMode == 0) begin
          mWord = mLfsr * 64 + mTs;
          mLfsr = ((mLfsr * 2) & 6) | (((mLfsr >> 2) ^ (mLfsr >> 1)) & 1);
        end else if (mMode == 1) begin
          h = mPat[0];
          mWord = h * 64 + mTs;
          for (int i = 0; i < 7; i++) mPat[i] = mPat[i+1];
          mPat[7] = h;
        end else mWord = mQ.pop_front();
        mPace = mGap;
      end else if (mPace > 0) mPace--;
      if (push) mQ.push_back(int'(rxSrc) * 64 + mTs);
      if (cfgWrEn) begin
        case (cfgAddr)
          2'd0: begin mRun = cfgData[0]; mMode = int'(cfgData[2:1]); end
          2'd1: mGap = int'(cfgData);
          2'd2: if (cfgData[2:0] != 0) mLfsr = int'(cfgData[2:0]);
          default: begin
            for (int i = 0; i < 7; i++) mPat[i] = mPat[i+1];
            mPat[7] = int'(cfgData[2:0]);
          end
        endcase
      end
      mTs = (mTs + 1) % 64;
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      if (!rstN) begin
        checks++;
        if (txValid !== 1'b0 || rxStall !== 1'b0) begin
          fails++;
          $display("FAIL R1 reset: txValid=%b rxStall=%b expected 0 0", txValid, rxStall);
        end
      end else begin
        checks++;
        if (txValid !== mValid[0]) begin
          fails++;
          $display("FAIL %s/R3 cycle %0d: txValid=%b expected %0d", tag, cyc, txValid, mValid);
        end else if (mValid && txData !== mWord[8:0]) begin
          fails++;
          $display("FAIL %s/R4 cycle %0d: txData=%h expected %h", tag, cyc, txData, mWord[8:0]);
        end
        checks++;
        if (rxStall !== expRxStall()) begin
          fails++;
          $display("FAIL R8 cycle %0d: rxStall=%b expected %0d", cyc, rxStall, expRxStall());
        end
      end
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic cfgWrite(input int a, input int d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 2'(a); cfgData = 6'(d);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stallRun(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      txStall = ((pat >> (i % 8)) & 1) != 0;
    end
    @(negedge clk);
    txStall = 1'b0;
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R4 time base and R5 random destinations, no stall
    tag = "R5";
    cfgWrite(0, 1);
    idle(20);
    // R2 and R3 with toggling and burst stalls
    tag = "R2";
    stallRun(40, 8'b0110_1101);
    stallRun(24, 8'b1111_1110);
    // R5 seed load and zero seed ignored mid-stream
    tag = "R5";
    cfgWrite(2, 5);
    idle(6);
    cfgWrite(2, 0);
    idle(10);
    // R9 pacing gaps
    tag = "R9";
    cfgWrite(1, 1);
    idle(12);
    cfgWrite(1, 3);
    stallRun(24, 8'b0001_1000);
    cfgWrite(1, 0);
    // R10 run bit off and mode 3
    tag = "R10";
    cfgWrite(0, 0);
    idle(8);
    cfgWrite(0, 7);
    idle(8);
    // R6 pattern sequence written while stopped, then rotated
    tag = "R6";
    cfgWrite(0, 2);
    for (int i = 0; i < 8; i++) cfgWrite(3, (i * 3 + 1) % 8);
    cfgWrite(0, 3);
    idle(20);
    stallRun(16, 8'b1010_0110);
    // R8 receive words ignored outside echo mode
    tag = "R8";
    cfgWrite(0, 0);
    idle(2);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rxValid = 1'b1; rxSrc = 3'(i + 2);
    end
    @(negedge clk); rxValid = 1'b0;
    // R7 echo replies, queue filled under downstream stall
    tag = "R7";
    cfgWrite(0, 5);
    @(negedge clk); txStall = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rxValid = 1'b1; rxSrc = 3'(7 - i);
    end
    @(negedge clk); rxValid = 1'b0; txStall = 1'b0;
    idle(10);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rxValid = (i % 3) != 2; rxSrc = 3'(i); txStall = (i % 4) == 1;
    end
    @(negedge clk); rxValid = 1'b0; txStall = 1'b0;
    idle(12);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule